// File: doc/BRIEF.md
# Fractional line clock synthesizer

The block generates one line-rate clock enable per line from a single fixed system clock of 38.88 MHz. Each line is set to either T1 (1.544 MHz nominal) or E1 (2.048 MHz nominal). Each line also takes a signed 8-bit frequency trim that moves its average output rate a few ppm above or below nominal. A control loop elsewhere computes the trim. The block saturates the trim to a legal range that depends on the mode. In coarse resolution only the upper nibble of the saturated trim is kept.

Each line has a 28-bit phase accumulator. Its increment is the nominal value for the line's mode plus the effective trim times a per-mode step. A carry out of the accumulator produces a one-system-clock enable pulse. Because the accumulator carries at evenly spread points, the long and short divide periods interleave and never bunch together. The output rate tracks the system clock exactly, with no internal correction.

Top module: `fsyn_line_clk_gen`

## Requirements
- R1: With mode T1 (line_e1 bit = 0) and hires = 1, the trim (two's complement, line i in line_set bits [8i+7:8i]) is saturated to the range -83..+88 before use.
- R2: With mode E1 (line_e1 bit = 1) and hires = 1, the trim is saturated to the range -128..+111.
- R3: With hires = 0, the low 4 bits of the trim are forced to zero after saturation. In T1 the effective values therefore lie in -96..+80, and in E1 they lie in -128..+96.
- R4: The increment is NOM + eff*STEP. NOM is floor(2^28 * f_line / 38880 kHz), giving 10660091 for T1 and 14139810 for E1. STEP is 20 in T1 and 11 in E1.
- R5: On each system clock the accumulator adds the increment modulo 2^28. line_pulse is high for exactly the one cycle after an addition that carried out.
- R6: With a fixed trim, consecutive gaps between pulses on a line differ by at most one system clock. All gaps lie between 18 and 26 cycles.
- R7: While rst_n is low all pulses are low and all accumulators are zero. After rst_n rises, the accumulators start adding on the third rising clock edge.
- R8: A change of trim, mode or hires is used by the next clock edge's addition, and the accumulator keeps its current phase.
- R9: Over a long window, the measured average rate matches the ppm offset given by R4 within 40 ppm. The offset stays inside +/-200 ppm in T1 and +/-100 ppm in E1 (plus that tolerance).
- R10: The lines are independent: each line's pulses depend only on its own trim and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 38.88 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hires | input | 1 | 1 = all 8 trim bits used, 0 = upper nibble only |
| line_set | input | NUM_LINES*8 | Packed signed trims, line i at bits [8i+7:8i] |
| line_e1 | input | NUM_LINES | Per-line mode, 0 = T1, 1 = E1 |
| line_pulse | output | NUM_LINES | Per-line one-cycle line clock enable |

## Verification
Four things are checked on every cycle:
- the saturated trim stays inside its mode and resolution range;
- the low nibble is zero in coarse mode;
- every pulse is one cycle wide;
- pulse spacing stays within the 18 to 26 cycle band, and pulses are quiet under reset.

Other behaviour only the bench scenarios can show. The behavioural reference compares exact pulse timing each clock, which covers the phase kept across trim changes and the two-cycle reset release. Long windows at the minimum, zero and maximum trims in both modes and both resolutions show the average ppm offset and the even interleaving of long and short periods.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
  // Saturation limits of the trim, per line mode
  localparam int T1_TRIM_MIN = -83;
  localparam int T1_TRIM_MAX = 88;
  localparam int E1_TRIM_MIN = -128;
  localparam int E1_TRIM_MAX = 111;
  // Number of low trim bits dropped in coarse resolution
  localparam int COARSE_DROP = 4;

  typedef enum logic {
    MODE_T1 = 1'b0,
    MODE_E1 = 1'b1
  } line_mode_e;
endpackage

// File: rtl/fsyn_trim_sat.sv
module fsyn_trim_sat
  import fsyn_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic signed [SET_W-1:0] trim_i,
  input  line_mode_e              mode_i,
  input  logic                    hires_i,
  output logic signed [SET_W-1:0] eff_o
);
  logic signed [SET_W-1:0] lo_lim;
  logic signed [SET_W-1:0] hi_lim;
  logic signed [SET_W-1:0] sat;

  always_comb begin
    if (mode_i == MODE_E1) begin
      lo_lim = SET_W'(E1_TRIM_MIN);
      hi_lim = SET_W'(E1_TRIM_MAX);
    end else begin
      lo_lim = SET_W'(T1_TRIM_MIN);
      hi_lim = SET_W'(T1_TRIM_MAX);
    end
  end

  always_comb begin
    if (trim_i < lo_lim)      sat = lo_lim;
    else if (trim_i > hi_lim) sat = hi_lim;
    else                      sat = trim_i;
  end

  // Coarse resolution truncates after saturation
  always_comb begin
    eff_o = sat;
    if (!hires_i) eff_o[COARSE_DROP-1:0] = '0;
  end
endmodule

// File: rtl/fsyn_incr.sv
module fsyn_incr
  import fsyn_pkg::*;
#(
  parameter int                 SET_W   = 8,
  parameter int                 ACC_W   = 28,
  parameter logic [ACC_W-1:0]   NOM_T1  = '0,
  parameter logic [ACC_W-1:0]   NOM_E1  = '0,
  parameter int                 STEP_T1 = 20,
  parameter int                 STEP_E1 = 11
) (
  input  logic signed [SET_W-1:0] eff_i,
  input  line_mode_e              mode_i,
  output logic [ACC_W-1:0]        inc_o
);
  logic signed [ACC_W-1:0] eff_ext;
  logic signed [ACC_W-1:0] step_s;
  logic signed [ACC_W-1:0] base_s;
  logic signed [ACC_W-1:0] sum_s;

  always_comb begin
    eff_ext = {{(ACC_W-SET_W){eff_i[SET_W-1]}}, eff_i};
    if (mode_i == MODE_E1) begin
      step_s = ACC_W'(STEP_E1);
      base_s = NOM_E1;
    end else begin
      step_s = ACC_W'(STEP_T1);
      base_s = NOM_T1;
    end
    sum_s = base_s + eff_ext * step_s;
    inc_o = sum_s;
  end
endmodule

// File: rtl/fsyn_phase_acc.sv
module fsyn_phase_acc #(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc_i,
  output logic             pulse_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             pulse_q;
  logic             pulse_d;
  logic [ACC_W:0]   wide_sum;

  always_comb begin
    wide_sum = {1'b0, acc_q} + {1'b0, inc_i};
    acc_d    = wide_sum[ACC_W-1:0];
    pulse_d  = wide_sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/fsyn_line_clk_gen.sv
module fsyn_line_clk_gen
  import fsyn_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int SET_W     = 8,
  parameter int ACC_W     = 28,
  parameter int SYS_KHZ   = 38880,
  parameter int T1_KHZ    = 1544,
  parameter int E1_KHZ    = 2048,
  parameter int STEP_T1   = 20,
  parameter int STEP_E1   = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hires,
  input  logic [NUM_LINES*SET_W-1:0] line_set,
  input  logic [NUM_LINES-1:0]       line_e1,
  output logic [NUM_LINES-1:0]       line_pulse
);
  localparam logic [63:0] ACC_ONE = 64'd1 << ACC_W;
  localparam logic [ACC_W-1:0] NOM_T1 = ACC_W'((ACC_ONE * 64'(T1_KHZ)) / 64'(SYS_KHZ));
  localparam logic [ACC_W-1:0] NOM_E1 = ACC_W'((ACC_ONE * 64'(E1_KHZ)) / 64'(SYS_KHZ));

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [NUM_LINES*SET_W-1:0] eff_flat;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic signed [SET_W-1:0] trim;
    logic signed [SET_W-1:0] eff;
    logic [ACC_W-1:0]        inc;
    line_mode_e              mode;

    assign trim = line_set[g*SET_W +: SET_W];
    assign mode = line_mode_e'(line_e1[g]);
    assign eff_flat[g*SET_W +: SET_W] = eff;

    fsyn_trim_sat #(.SET_W(SET_W)) i_sat (
      .trim_i (trim),
      .mode_i (mode),
      .hires_i(hires),
      .eff_o  (eff)
    );

    fsyn_incr #(
      .SET_W  (SET_W),
      .ACC_W  (ACC_W),
      .NOM_T1 (NOM_T1),
      .NOM_E1 (NOM_E1),
      .STEP_T1(STEP_T1),
      .STEP_E1(STEP_E1)
    ) i_incr (
      .eff_i (eff),
      .mode_i(mode),
      .inc_o (inc)
    );

    fsyn_phase_acc #(.ACC_W(ACC_W)) i_acc (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .inc_i  (inc),
      .pulse_o(line_pulse[g])
    );
  end
endmodule

// File: rtl/fsyn_line_clk_chk.sv
module fsyn_line_clk_chk #(
  parameter int NUM_LINES = 4,
  parameter int SET_W     = 8,
  parameter int GAP_MIN   = 18,
  parameter int GAP_MAX   = 26
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hires,
  input logic [NUM_LINES-1:0]       line_e1,
  input logic [NUM_LINES-1:0]       line_pulse,
  input logic [NUM_LINES*SET_W-1:0] eff_flat
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    logic signed [SET_W-1:0] eff;
    logic [5:0]              gap_q;
    logic                    seen_q;

    assign eff = eff_flat[g*SET_W +: SET_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gap_q  <= '0;
        seen_q <= 1'b0;
      end else if (line_pulse[g]) begin
        gap_q  <= 6'd1;
        seen_q <= 1'b1;
      end else if (gap_q != 6'd63) begin
        gap_q  <= gap_q + 6'd1;
      end
    end

    a_r1_t1_range: assert property (@(posedge clk) disable iff (!rst_n)
      (hires && !line_e1[g]) |-> (eff >= -83 && eff <= 88));

    a_r2_e1_range: assert property (@(posedge clk) disable iff (!rst_n)
      (hires && line_e1[g]) |-> (eff <= 111));

    a_r3_coarse_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      !hires |-> (eff[3:0] == 4'd0));

    a_r3_coarse_t1_range: assert property (@(posedge clk) disable iff (!rst_n)
      (!hires && !line_e1[g]) |-> (eff >= -96 && eff <= 80));

    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      line_pulse[g] |=> !line_pulse[g]);

    a_r6_gap_band: assert property (@(posedge clk) disable iff (!rst_n)
      (line_pulse[g] && seen_q) |-> (gap_q >= 6'(GAP_MIN) && gap_q <= 6'(GAP_MAX)));

    a_r7_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |-> !line_pulse[g]);
  end
endmodule

bind fsyn_line_clk_gen fsyn_line_clk_chk #(
  .NUM_LINES(NUM_LINES),
  .SET_W    (SET_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hires     (hires),
  .line_e1   (line_e1),
  .line_pulse(line_pulse),
  .eff_flat  (eff_flat)
);

// File: tb/test_fsyn_line_clk_gen.sv
`timescale 1ns/1ps
module test_fsyn_line_clk_gen;
  localparam int N   = 6;
  localparam int SW  = 8;
  localparam int WIN = 60000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic            hires;
  logic [N*SW-1:0] line_set;
  logic [N-1:0]    line_e1;
  logic [N-1:0]    line_pulse;

  fsyn_line_clk_gen #(.NUM_LINES(N)) i_fsyn_line_clk_gen (
    .clk(clk), .rst_n(rst_n), .hires(hires),
    .line_set(line_set), .line_e1(line_e1), .line_pulse(line_pulse)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  // Behavioural reference state
  longint m_acc [N];
  bit     m_pls [N];
  int     m_sync;
  int     trim  [N];
  bit     e1    [N];

  // Window measurement
  bit meas;
  int n_cnt [N];
  int t_first [N];
  int t_last [N];
  int g_min [N];
  int g_max [N];

  function automatic int eff_of(int t, bit is_e1, bit hr);
    int v;
    v = t;
    if (is_e1) begin
      if (v < -128) v = -128;
      if (v > 111)  v = 111;
    end else begin
      if (v < -83) v = -83;
      if (v > 88)  v = 88;
    end
    if (!hr) v = v & ~15;
    return v;
  endfunction

  function automatic longint nom_of(bit is_e1);
    return ((longint'(1) << 28) * (is_e1 ? 2048 : 1544)) / 38880;
  endfunction

  function automatic longint inc_of(int t, bit is_e1, bit hr);
    return nom_of(is_e1) + longint'(eff_of(t, is_e1, hr)) * (is_e1 ? 20'd11 : 20'd20);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_r(bit ok, string req, string what, real act, real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %f expected %f", req, what, act, exp);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      line_set[i*SW +: SW] = SW'(trim[i]);
      line_e1[i] = e1[i];
    end
  endtask

  // One clock: advance the reference with the inputs the edge will see,
  // then compare away from the edge.
  task automatic tick();
    int mism;
    if (!rst_n) begin
      m_sync = 0;
      for (int i = 0; i < N; i++) begin m_acc[i] = 0; m_pls[i] = 0; end
    end else if (m_sync < 2) begin
      m_sync++;
      for (int i = 0; i < N; i++) m_pls[i] = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        m_acc[i] += inc_of(trim[i], e1[i], hires);
        m_pls[i] = (m_acc[i] >= (longint'(1) << 28));
        if (m_pls[i]) m_acc[i] -= (longint'(1) << 28);
      end
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    mism = 0;
    for (int i = 0; i < N; i++) if (line_pulse[i] != m_pls[i]) mism++;
    // R5 R8 R10: exact per-line pulse timing against the reference
    chk(mism == 0, "R5", "pulse vector vs reference", longint'(line_pulse),
        longint'({m_pls[5], m_pls[4], m_pls[3], m_pls[2], m_pls[1], m_pls[0]}));
    if (meas) begin
      for (int i = 0; i < N; i++) if (line_pulse[i]) begin
        if (n_cnt[i] > 0) begin
          if (cyc - t_last[i] < g_min[i]) g_min[i] = cyc - t_last[i];
          if (cyc - t_last[i] > g_max[i]) g_max[i] = cyc - t_last[i];
        end else t_first[i] = cyc;
        t_last[i] = cyc;
        n_cnt[i]++;
      end
    end
  endtask

  task automatic run_window(string tag);
    for (int i = 0; i < N; i++) begin
      n_cnt[i] = 0; g_min[i] = 1000; g_max[i] = 0;
    end
    meas = 1;
    repeat (WIN) tick();
    meas = 0;
    for (int i = 0; i < N; i++) begin
      real f, nomr, ratio, pm, pe, lim;
      f     = e1[i] ? 2048.0 : 1544.0;
      nomr  = 268435456.0 * f / 38880.0;
      ratio = real'(n_cnt[i] - 1) * 38880.0 / (real'(t_last[i] - t_first[i]) * f);
      pm    = (ratio - 1.0) * 1.0e6;
      pe    = real'(eff_of(trim[i], e1[i], hires)) * (e1[i] ? 11.0 : 20.0) / nomr * 1.0e6;
      lim   = e1[i] ? 100.0 : 200.0;
      // R9: average offset matches the increment, inside the mode band
      chk_r((pm - pe) < 40.0 && (pe - pm) < 40.0, "R9", {tag, " ppm offset"}, pm, pe);
      chk_r(pm < lim + 40.0 && pm > -lim - 40.0, "R9", {tag, " ppm band"}, pm, lim);
      // R6: long and short periods interleave
      chk(g_max[i] - g_min[i] <= 1, "R6", {tag, " gap spread"}, g_max[i] - g_min[i], 1);
      chk(g_min[i] >= 18 && g_max[i] <= 26, "R6", {tag, " gap range"}, g_min[i], 18);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lcg;
    rst_n = 1'b0;
    hires = 1'b1;
    meas  = 0;
    m_sync = 0;
    for (int i = 0; i < N; i++) begin m_acc[i] = 0; m_pls[i] = 0; end
    // lines 0..2 T1 at min/zero/max, lines 3..5 E1 at min/zero/max
    trim = '{-128, 0, 127, -128, 0, 127};
    e1   = '{0, 0, 0, 1, 1, 1};
    drive();
    #1;
    // R7: quiet in reset
    chk(line_pulse == '0, "R7", "pulses in reset", longint'(line_pulse), 0);
    repeat (5) tick();
    rst_n = 1'b1;
    // R7: no pulse before the accumulators start (checked by the reference)
    repeat (30) tick();

    // R1 R2 R4: full resolution extremes
    run_window("hires");

    // R3: coarse resolution, truncated after saturation
    hires = 1'b0;
    repeat (100) tick();
    run_window("coarse");

    // R8 R10: frequent trim, mode and resolution changes, phase kept
    lcg = 12345;
    for (int k = 0; k < 150; k++) begin
      for (int i = 0; i < N; i++) begin
        lcg = lcg * 1103515245 + 12345;
        trim[i] = int'(signed'(8'(lcg >>> 16)));
        e1[i]   = lcg[24];
      end
      hires = lcg[27];
      drive();
      repeat (17 + (k % 23)) tick();
    end

    // R7: reset in mid-run clears everything asynchronously
    rst_n = 1'b0;
    #1;
    chk(line_pulse == '0, "R7", "pulses after async reset", longint'(line_pulse), 0);
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (200) tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule